// File: doc/BRIEF.md
# MDIO Management Master with Clause 22 and Clause 45 Access

This block lets software reach the management registers of external PHYs over a two-wire MDIO bus. Software sees two 32-bit registers on a simple write/read port. The command register holds the PHY address, a 5-bit register-or-device field, an MDC rate select, an operation code, a mode bit, an address-skip bit and a busy flag. The data register holds 16 bits of data in its lower half. In Clause 45 mode its upper half holds the register address inside the selected device. The block divides the system clock down to MDC. It drives MDIO as an output, output-enable and input triple, and it stores the word that a PHY returns.

Software first loads the data register. It then writes the command register with bit 0 set. Bit 0 reads back as 1 until the whole transaction ends, so software polls it for idle. When the mode bit is clear, one Clause 22 frame goes out. When the mode bit is set, the block sends an address frame and then the read or write frame, all from one command write. The skip bit drops the address frame. Every frame begins with 32 preamble ones.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, both registers read as zero, MDC is high and the MDIO output enable is low.
- R2: A command write (wr_addr=0) with bit 0 set while idle starts a transaction and stores bits 31:1. Bit 0 then reads 1 for exactly 64*F*D clock cycles after the write edge (F frames, divisor D), and 0 after that. A command write with bit 0 clear only stores the fields and starts nothing.
- R3: The MDC divisor D is chosen by command bits 11:8: code 0 gives 42, 1 gives 62, 2 gives 16, 3 gives 26, 4 gives 102 and 5 gives 124. Any other code also gives 124. MDC spends D/2 cycles low and D/2 cycles high.
- R4: With bit 1 clear, one frame is sent MSB first: 32 ones, start 01, opcode 10 for a read or 01 for a write, the PHY address (bits 25:21), the register number (bits 20:16), turnaround 10 and 16 data bits. A read is requested only when bits 3:2 equal 3. Every other value is a write.
- R5: With bit 1 set and bit 4 clear, an address frame is sent first (start 00, opcode 00, PHY address, device address from bits 20:16, turnaround 10, data = data register bits 31:16). Then a second frame follows with start 00 and opcode 11 for a read or 01 for a write.
- R6: With bits 1 and 4 both set, only the second Clause 45 frame is sent.
- R7: On a read frame, the output enable is low from the first turnaround bit to the end of the frame. On every other bit of a transaction it is high.
- R8: Each frame bit is presented on MDIO when MDC falls, and MDIO changes at no other time. A transaction of F frames produces exactly 64*F MDC falling edges.
- R9: On a read, the 16 bits sampled when MDC rises during the data phase (first bit in the MSB) replace data register bits 15:0 in the cycle in which busy clears. Bits 31:16 keep their value.
- R10: Writes to either register while busy is set are ignored.
- R11: While no transaction runs, MDC is high and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 command, 1 data |
| wr_data | input | 32 | Register write value |
| rd_addr | input | 1 | Read target: 0 command, 1 data |
| rd_data | output | 32 | Selected register value (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen on the pad |

## Verification
The result that carries the timing is busy. It must read 1 at the falling clock edge that ends the 64*F*D-1 edges after the command write edge, and 0 one edge later. The bench computes F and D from the vector and samples at exactly those two points, which pins down the divisor, the frame count and the moment of completion. Frame bits are taken one clock after each MDC fall, when both mdio_o and the enable have settled. The bench drives PHY data on that same edge, many cycles before the next rise. The read data and the register contents are checked after busy has cleared.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int REG_W    = 32;
  localparam int WORD_W   = 16;
  localparam int BODY_W   = 32;        // start..data, without preamble
  localparam logic [1:0] OPC_READ = 2'd3;

  // system-clock cycles per MDC period for a rate code
  function automatic int unsigned mdc_divisor(input logic [3:0] code);
    case (code)
      4'd0:    return 42;
      4'd1:    return 62;
      4'd2:    return 16;
      4'd3:    return 26;
      4'd4:    return 102;
      default: return 124;
    endcase
  endfunction

  // frame body after the preamble: start, op, phy, reg/dev, turnaround, data
  function automatic logic [BODY_W-1:0] frame_body(
    input logic [1:0] st, input logic [1:0] op, input logic [4:0] pa,
    input logic [4:0] ra, input logic [WORD_W-1:0] dat);
    return {st, op, pa, ra, 2'b10, dat};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_mgmt_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] clk_sel,
  output logic       mdc,
  output logic       fall_evt,
  output logic       rise_evt
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             at_end;

  always_comb begin
    half_m1  = CNT_W'(mdc_divisor(clk_sel) / 2 - 1);
    at_end   = (cnt == half_m1);
    fall_evt = run && at_end && mdc;
    rise_evt = run && at_end && !mdc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b1;
    end else if (at_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= half_m1); // R3

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int PREAMBLE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [4:0]        phy_addr,
  input  logic [4:0]        reg_dev,
  input  logic              c45,
  input  logic              skip_addr,
  input  logic              rd_req,
  input  logic [REG_W-1:0]  data_in,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rd_word,
  output logic              mdio_o,
  output logic              mdio_oe
);

  localparam int FRAME_BITS = PREAMBLE_BITS + BODY_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = PREAMBLE_BITS + 14;
  localparam int DATA_POS   = PREAMBLE_BITS + 16;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [PREAMBLE_BITS-1:0] PRE = {PREAMBLE_BITS{1'b1}};

  logic [FRAME_BITS-1:0] frame_q;
  logic [BODY_W-1:0]     second_q;
  logic [BIT_W-1:0]      bitn;
  logic                  pend_q;
  logic                  cur_read;
  logic                  txn_read;
  logic [WORD_W-1:0]     shreg;
  logic [BODY_W-1:0]     body_c22, body_c45a, body_c45m;
  logic                  in_release;
  logic                  in_data;
  logic                  frame_end;

  always_comb begin
    body_c22  = frame_body(2'b01, rd_req ? 2'b10 : 2'b01, phy_addr, reg_dev,
                           data_in[WORD_W-1:0]);
    body_c45a = frame_body(2'b00, 2'b00, phy_addr, reg_dev,
                           data_in[REG_W-1:WORD_W]);
    body_c45m = frame_body(2'b00, rd_req ? 2'b11 : 2'b01, phy_addr, reg_dev,
                           data_in[WORD_W-1:0]);
    in_release = cur_read && (bitn >= BIT_W'(TA_POS));
    in_data    = cur_read && (bitn >= BIT_W'(DATA_POS));
    frame_end  = rise_evt && (bitn == LAST_BIT);
    done       = frame_end && !pend_q;
    rd_word    = {shreg[WORD_W-2:0], mdio_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q  <= '0;
      second_q <= '0;
      bitn     <= '0;
      pend_q   <= 1'b0;
      cur_read <= 1'b0;
      txn_read <= 1'b0;
      shreg    <= '0;
      busy     <= 1'b0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      bitn     <= '0;
      shreg    <= '0;
      txn_read <= rd_req;
      second_q <= body_c45m;
      if (c45 && !skip_addr) begin
        frame_q  <= {PRE, body_c45a};
        pend_q   <= 1'b1;
        cur_read <= 1'b0;
      end else begin
        frame_q  <= {PRE, c45 ? body_c45m : body_c22};
        pend_q   <= 1'b0;
        cur_read <= rd_req;
      end
    end else if (busy) begin
      if (fall_evt) begin
        mdio_o  <= frame_q[FRAME_BITS-1];
        frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
        mdio_oe <= !in_release;
      end
      if (rise_evt) begin
        if (in_data) shreg <= rd_word;
        if (frame_end) begin
          bitn <= '0;
          if (pend_q) begin
            frame_q  <= {PRE, second_q};
            pend_q   <= 1'b0;
            cur_read <= txn_read;
          end else begin
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
          end
        end else begin
          bitn <= bitn + 1'b1;
        end
      end
    end
  end

  AST_OE_WITHIN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy); // R7

  AST_NO_DRIVE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_data && bitn > BIT_W'(DATA_POS)) |-> !mdio_oe); // R7

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int PREAMBLE_BITS = 32,
  parameter int DIV_CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  logic [REG_W-1:1]  cmd_q;
  logic [REG_W-1:0]  data_q;
  logic              busy;
  logic              done;
  logic              start;
  logic              cmd_wr;
  logic              data_wr;
  logic              fall_evt;
  logic              rise_evt;
  logic [WORD_W-1:0] rd_word;
  logic              cmd_is_read;

  always_comb begin
    cmd_wr      = wr_en && !wr_addr && !busy;
    data_wr     = wr_en &&  wr_addr && !busy;
    start       = cmd_wr && wr_data[0];
    cmd_is_read = (cmd_q[3:2] == OPC_READ);
    rd_data     = rd_addr ? data_q : {cmd_q, busy};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_wr)  cmd_q  <= wr_data[REG_W-1:1];
      if (data_wr) data_q <= wr_data;
      if (done && cmd_is_read) data_q[WORD_W-1:0] <= rd_word;
    end
  end

  mdio_mdc_gen #(.CNT_W(DIV_CNT_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy), .clk_sel(cmd_q[11:8]),
    .mdc(mdc), .fall_evt(fall_evt), .rise_evt(rise_evt)
  );

  mdio_frame_seq #(.PREAMBLE_BITS(PREAMBLE_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phy_addr(wr_data[25:21]), .reg_dev(wr_data[20:16]),
    .c45(wr_data[1]), .skip_addr(wr_data[4]),
    .rd_req(wr_data[3:2] == OPC_READ), .data_in(data_q),
    .fall_evt(fall_evt), .rise_evt(rise_evt), .mdio_i(mdio_i),
    .busy(busy), .done(done), .rd_word(rd_word),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc && !mdio_oe)); // R11

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc)); // R8

  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(cmd_q)); // R10

  AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr && !done) |=> $stable(data_q)); // R10

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(data_q[REG_W-1:WORD_W])); // R9

endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int DIVS [8]   = '{42, 62, 16, 26, 102, 124, 124, 124};

  typedef struct packed {
    logic        c45;
    logic        skip;
    logic        rd;
    logic [3:0]  code;
    logic [4:0]  pa;
    logic [4:0]  ra;
    logic [15:0] hi;
    logic [15:0] wd;
    logic [15:0] phy;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VT [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 4'd2, 5'h03, 5'h0A, 16'h0000, 16'hA5C3, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 4'd3, 5'h1F, 5'h01, 16'hBEEF, 16'h0000, 16'h1234},
    '{1'b1, 1'b0, 1'b0, 4'd2, 5'h02, 5'h1E, 16'h8001, 16'h0F0F, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 4'd0, 5'h11, 5'h03, 16'h0020, 16'h0000, 16'hC0DE},
    '{1'b1, 1'b1, 1'b1, 4'd2, 5'h07, 5'h07, 16'h4444, 16'h0000, 16'h5A5A},
    '{1'b1, 1'b1, 1'b0, 4'd1, 5'h00, 5'h1F, 16'h0001, 16'hFFFF, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 4'd4, 5'h15, 5'h10, 16'h7777, 16'h0000, 16'h8421}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;

  // PHY-side recorder
  logic         mdc_last = 1'b1;
  int           cap_n = 0;
  logic [127:0] cap_o, cap_oe;
  logic [15:0]  phy_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_master u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(negedge clk) begin
    if (mdc_last && !mdc) begin
      if (cap_n < 128) begin
        cap_o[cap_n]  = mdio_o;
        cap_oe[cap_n] = mdio_oe;
      end
      if ((cap_n % 64) >= 48) mdio_i = phy_word[15 - ((cap_n % 64) - 48)];
      else                    mdio_i = 1'b1;
      cap_n = cap_n + 1;
    end
    mdc_last = mdc;
  end

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic int div_of(input logic [3:0] code);
    return (code > 4'd7) ? 124 : DIVS[code];
  endfunction

  function automatic logic [63:0] mk_frame(input logic [1:0] st,
    input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
    input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
  endfunction

  function automatic logic [31:0] mk_cmd(input vec_t v);
    return {6'b0, v.pa, v.ra, 4'b0, v.code, 3'b0, v.skip,
            v.rd ? 2'b11 : 2'b01, v.c45, 1'b1};
  endfunction

  // start a transaction and check busy at its last busy cycle and just after
  task automatic run_busy(input logic [31:0] cmd, input int nfr, input int dv,
                          input string req);
    logic [31:0] r;
    int t;
    t = 64 * nfr * dv;
    cap_n = 0;
    wr_reg(1'b0, cmd);
    repeat (t - 1) @(negedge clk);
    rd_reg(1'b0, r);
    check({req, " busy held"}, r, cmd);
    @(negedge clk);
    rd_reg(1'b0, r);
    check({req, " busy cleared"}, r, cmd & 32'hFFFF_FFFE);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd_reg(1'b0, r); check("R1 cmd", r, 32'h0);
    rd_reg(1'b1, r); check("R1 data", r, 32'h0);
    check("R1 mdc/oe", {30'b0, mdc, mdio_oe}, 32'h2);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      int nfr, nb, bad_o, bad_oe;
      logic [63:0] f0, f1;
      logic [127:0] ex_o, ex_oe;
      string rq;
      v = VT[i];
      nfr = (v.c45 && !v.skip) ? 2 : 1;
      nb  = 64 * nfr;
      if (!v.c45) begin
        f0 = mk_frame(2'b01, v.rd ? 2'b10 : 2'b01, v.pa, v.ra, v.wd);
        f1 = '0;
      end else begin
        f1 = mk_frame(2'b00, v.rd ? 2'b11 : 2'b01, v.pa, v.ra, v.wd);
        f0 = v.skip ? f1 : mk_frame(2'b00, 2'b00, v.pa, v.ra, v.hi);
      end
      ex_o = '0; ex_oe = '0;
      for (int j = 0; j < 64; j++) begin
        ex_o[j]  = f0[63 - j];
        ex_oe[j] = !(v.rd && nfr == 1 && j >= 46);
        if (nfr == 2) begin
          ex_o[64 + j]  = f1[63 - j];
          ex_oe[64 + j] = !(v.rd && j >= 46);
        end
      end
      rq = !v.c45 ? "R4" : (v.skip ? "R6" : "R5");
      phy_word = v.phy;
      wr_reg(1'b1, {v.hi, v.wd});
      run_busy(mk_cmd(v), nfr, div_of(v.code), "R2/R3");
      check("R8 fall count", cap_n, nb);
      bad_o = 0; bad_oe = 0;
      for (int j = 0; j < nb; j++) begin
        if (cap_oe[j] !== ex_oe[j]) bad_oe++;
        if (ex_oe[j] && cap_o[j] !== ex_o[j]) bad_o++;
      end
      check({rq, " frame bits"}, bad_o, 0);
      check("R7 enable pattern", bad_oe, 0);
      rd_reg(1'b1, r);
      check(v.rd ? "R9 read capture" : "R9 data kept", r,
            {v.hi, v.rd ? v.phy : v.wd});
      check("R11 idle bus", {30'b0, mdc, mdio_oe}, 32'h2);
    end

    // R2: command write without bit 0 stores fields only
    cap_n = 0;
    wr_reg(1'b0, 32'h0062_0C0C);
    repeat (200) @(negedge clk);
    rd_reg(1'b0, r); check("R2 no start", r, 32'h0062_0C0C);
    check("R2 no mdc activity", cap_n, 0);

    // R10: writes during busy are ignored
    wr_reg(1'b1, 32'h1357_2468);
    wr_reg(1'b0, 32'h0065_0205);
    repeat (100) @(negedge clk);
    wr_reg(1'b1, 32'hDEAD_BEEF);
    wr_reg(1'b0, 32'h03FF_0F1F);
    wait (rd_data[0] == 1'b0 || rd_addr == 1'b1);
    rd_addr = 1'b0;
    repeat (1100) @(negedge clk);
    rd_reg(1'b0, r); check("R10 cmd unchanged", r, 32'h0065_0204);
    rd_reg(1'b1, r); check("R10 data unchanged", r, 32'h1357_2468);

    // R3: unlisted rate code falls back to divisor 124
    run_busy(32'h0021_0905, 1, 124, "R3 fallback");
    check("R8 fallback falls", cap_n, 64);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule